// File: doc/BRIEF.md
# I2C Master Register and Queue Front End

This block sits between a processor's APB port and a byte-level I2C engine. Software sets up the engine through a control register, a prescale register and an interrupt-enable register. It sends I2C instructions by writing a write-only command register. Each write becomes one entry in a command queue, and the engine takes entries from that queue in the order they were written. Bytes that the engine receives from a slave go into a read-data queue. Software takes them out one at a time by reading the read-data register.

A status register collects the state of both queues and of the engine. Error conditions are held in sticky flags, and reading the status register clears them. Reading the read-data register when its queue is empty does not stall the bus: the read returns zero and records an underflow. Writing a command into a full queue drops the command and records an overflow. A single level interrupt line tells the processor that an enabled condition has occurred. Every APB transfer completes with no wait states.

Top module: `apb_i2c_front`

## Requirements
- R1: After reset, every register reads zero, both queues are empty, `irq` is 0, `eng_cmd_valid` is 0 and all `cfg_*` outputs are 0.
- R2: Register offsets are 0x00 control, 0x04 interrupt enable, 0x08 prescale, 0x0C command, 0x10 read data and 0x14 status.
  - Control bit 7 enables the engine, bit 6 selects the clock source, bit 5 enables the divider and bits 4:0 hold the low divide value.
  - Interrupt enable uses bits 4:0, one bit per status bit. Prescale uses bits PS_W-1:0.
  - All three registers read back what was written and drive the `cfg_*` outputs.
- R3: Commands reach `eng_cmd_data` in the order they were written.
  - `eng_cmd_valid` is 1 only while control bit 7 is 1 and the command queue is not empty.
  - The head entry is removed on a cycle where `eng_cmd_valid` and `eng_cmd_ready` are both 1. Until then it stays stable.
- R4: The command queue holds CMD_DEPTH entries. A command write that arrives while the queue is full is dropped and sets the overflow flag.
- R5: Status bit 0 means the read-data queue is not empty. Bit 1 means the command queue is full. Bit 2 is command overflow, bit 3 is read underflow and bit 4 is bus error. A pulse on `eng_bus_err` sets bit 4.
- R6: A status read clears bits 2 to 4 after the read. If a flag is set in the same cycle as the read, the set wins.
- R7: A read of the read-data register returns the oldest byte and removes it. A successful read also clears the underflow flag. A read while the queue is empty returns 0 and sets underflow.
- R8: `irq` is a register.
  - Its next value is 0 in a cycle with a status read.
  - Otherwise its next value is `irq` OR (any status bit AND its enable bit).
  - A still-true level flag therefore raises `irq` again one cycle after the read.
- R9: `pready` is always 1 and `pslverr` is always 0.
  - Writes to the status or read-data offsets have no effect.
  - Reads of the command offset and of unmapped offsets return 0.
- R10: The read-data queue holds RD_DEPTH entries. A byte delivered by the engine while the queue is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| eng_cmd_valid | output | 1 | Command available to the engine |
| eng_cmd_ready | input | 1 | Engine takes the head command |
| eng_cmd_data | output | CMD_W | Head command |
| eng_rd_valid | input | 1 | Engine delivers a received byte |
| eng_rd_data | input | 8 | Received byte |
| eng_bus_err | input | 1 | Engine reports a bus error (pulse) |
| cfg_enable | output | 1 | Engine enable |
| cfg_clk_sel | output | 1 | Clock source select |
| cfg_div_en | output | 1 | Divider enable |
| cfg_div_low | output | 5 | Low divide value |
| cfg_prescale | output | PS_W | Prescale value |
| irq | output | 1 | Level interrupt |

## Verification
The bench keeps the command queue at its default depth of 32. Filling it through the register port therefore exercises the full flag and the dropped thirty-third write. The bench builds the read-data queue with RD_DEPTH = 4, so a short burst of engine bytes reaches the full and drop case. That depth also lets the bench empty the queue and then read it once more to produce an underflow. A behavioural model with queues is stepped beside the design, and the two are compared on every cycle. This comparison covers the cases where a status read and an interrupt re-assertion happen in nearby cycles.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;

    localparam int DATA_W = 32;
    localparam int STAT_W = 5;

    // word index (paddr[4:2]) of each register
    localparam logic [2:0] IDX_CTRL   = 3'd0;
    localparam logic [2:0] IDX_IEN    = 3'd1;
    localparam logic [2:0] IDX_PRESC  = 3'd2;
    localparam logic [2:0] IDX_CMD    = 3'd3;
    localparam logic [2:0] IDX_RDDATA = 3'd4;
    localparam logic [2:0] IDX_STATUS = 3'd5;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_IEN,
        SEL_PRESC,
        SEL_CMD,
        SEL_RDDATA,
        SEL_STATUS,
        SEL_NONE
    } reg_sel_e;

    // control register, bit 7 is the engine enable
    typedef struct packed {
        logic       enable;
        logic       clk_sel;
        logic       div_en;
        logic [4:0] div_low;
    } ctrl_t;

    // status register, bit 0 first from the right
    typedef struct packed {
        logic bus_err;
        logic rd_ufl;
        logic cmd_ovf;
        logic cmd_full;
        logic rd_ready;
    } status_t;

    function automatic reg_sel_e decode_idx(input logic [2:0] idx);
        case (idx)
            IDX_CTRL:   return SEL_CTRL;
            IDX_IEN:    return SEL_IEN;
            IDX_PRESC:  return SEL_PRESC;
            IDX_CMD:    return SEL_CMD;
            IDX_RDDATA: return SEL_RDDATA;
            IDX_STATUS: return SEL_STATUS;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/i2cfe_fifo.sv
module i2cfe_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    assign empty = (count == '0);
    assign full  = (count == CMAX);
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R4 / R10: the callers must drop pushes into a full queue
    p_push_not_full_r4: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    p_pop_not_empty_r10: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
        count <= CMAX);

endmodule

// File: rtl/i2cfe_regs.sv
module i2cfe_regs
    import i2cfe_pkg::*;
#(
    parameter int PS_W  = 8,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             wr_ien,
    input  logic             wr_presc,
    input  logic [REG_W-1:0] wdata,
    output ctrl_t            ctrl,
    output logic [STAT_W-1:0] ien,
    output logic [PS_W-1:0]  presc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            ien   <= '0;
            presc <= '0;
        end else begin
            if (wr_ctrl)  ctrl  <= ctrl_t'(wdata[7:0]);
            if (wr_ien)   ien   <= wdata[STAT_W-1:0];
            if (wr_presc) presc <= wdata[PS_W-1:0];
        end
    end

    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl));

endmodule

// File: rtl/i2cfe_status.sv
module i2cfe_status
    import i2cfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_ovf,
    input  logic              set_ufl,
    input  logic              clr_ufl,
    input  logic              set_bus,
    input  logic              clr_rd,
    input  logic              rd_ready,
    input  logic              cmd_full,
    input  logic [STAT_W-1:0] ien,
    output status_t           stat,
    output logic              irq
);
    logic ovf_q, ufl_q, bus_q;

    assign stat = '{bus_err: bus_q, rd_ufl: ufl_q, cmd_ovf: ovf_q,
                    cmd_full: cmd_full, rd_ready: rd_ready};

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            ufl_q <= 1'b0;
            bus_q <= 1'b0;
            irq   <= 1'b0;
        end else begin
            ovf_q <= set_ovf | (ovf_q & ~clr_rd);
            ufl_q <= set_ufl | (ufl_q & ~clr_rd & ~clr_ufl);
            bus_q <= set_bus | (bus_q & ~clr_rd);
            irq   <= clr_rd ? 1'b0 : (irq | (|(stat & ien)));
        end
    end

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr_rd |=> !irq);
    p_bus_set_r5: assert property (@(posedge clk) disable iff (rst)
        set_bus |=> stat.bus_err);
    p_ovf_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_rd && !set_ovf) |=> !stat.cmd_ovf);
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (stat.cmd_ovf && !clr_rd) |=> stat.cmd_ovf);

endmodule

// File: rtl/apb_i2c_front.sv
module apb_i2c_front
    import i2cfe_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int CMD_W     = 8,
    parameter int CMD_DEPTH = 32,
    parameter int RD_DEPTH  = 8,
    parameter int PS_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              eng_cmd_valid,
    input  logic              eng_cmd_ready,
    output logic [CMD_W-1:0]  eng_cmd_data,
    input  logic              eng_rd_valid,
    input  logic [7:0]        eng_rd_data,
    input  logic              eng_bus_err,
    output logic              cfg_enable,
    output logic              cfg_clk_sel,
    output logic              cfg_div_en,
    output logic [4:0]        cfg_div_low,
    output logic [PS_W-1:0]   cfg_prescale,
    output logic              irq
);
    localparam int REG_W = (PS_W > 8) ? PS_W : 8;

    reg_sel_e          sel;
    logic              acc, wr_acc, rd_acc;
    ctrl_t             ctrl;
    logic [STAT_W-1:0] ien;
    status_t           stat;
    logic              cmd_empty, cmd_full, cmd_push, cmd_pop, cmd_wr;
    logic              rd_empty, rd_full, rd_push, rd_pop, rd_req;
    logic [7:0]        rd_head;
    logic              unused_bits;

    assign unused_bits = ^{paddr, pwdata};

    assign sel    = decode_idx(paddr[4:2]);
    assign acc    = psel & penable;
    assign wr_acc = acc & pwrite;
    assign rd_acc = acc & ~pwrite;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    i2cfe_regs #(.PS_W(PS_W), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_ctrl  (wr_acc && sel == SEL_CTRL),
        .wr_ien   (wr_acc && sel == SEL_IEN),
        .wr_presc (wr_acc && sel == SEL_PRESC),
        .wdata    (pwdata[REG_W-1:0]),
        .ctrl     (ctrl),
        .ien      (ien),
        .presc    (cfg_prescale)
    );

    assign cfg_enable  = ctrl.enable;
    assign cfg_clk_sel = ctrl.clk_sel;
    assign cfg_div_en  = ctrl.div_en;
    assign cfg_div_low = ctrl.div_low;

    // command queue: processor pushes, engine pops
    assign cmd_wr        = wr_acc && sel == SEL_CMD;
    assign cmd_push      = cmd_wr & ~cmd_full;
    assign eng_cmd_valid = ctrl.enable & ~cmd_empty;
    assign cmd_pop       = eng_cmd_valid & eng_cmd_ready;

    i2cfe_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk       (clk),
        .rst       (rst),
        .push      (cmd_push),
        .push_data (pwdata[CMD_W-1:0]),
        .pop       (cmd_pop),
        .head      (eng_cmd_data),
        .empty     (cmd_empty),
        .full      (cmd_full)
    );

    // read-data queue: engine pushes, processor pops
    assign rd_req  = rd_acc && sel == SEL_RDDATA;
    assign rd_push = eng_rd_valid & ~rd_full;
    assign rd_pop  = rd_req & ~rd_empty;

    i2cfe_fifo #(.W(8), .DEPTH(RD_DEPTH)) u_rd_q (
        .clk       (clk),
        .rst       (rst),
        .push      (rd_push),
        .push_data (eng_rd_data),
        .pop       (rd_pop),
        .head      (rd_head),
        .empty     (rd_empty),
        .full      (rd_full)
    );

    i2cfe_status u_status (
        .clk      (clk),
        .rst      (rst),
        .set_ovf  (cmd_wr & cmd_full),
        .set_ufl  (rd_req & rd_empty),
        .clr_ufl  (rd_pop),
        .set_bus  (eng_bus_err),
        .clr_rd   (rd_acc && sel == SEL_STATUS),
        .rd_ready (~rd_empty),
        .cmd_full (cmd_full),
        .ien      (ien),
        .stat     (stat),
        .irq      (irq)
    );

    always_comb begin
        prdata = '0;
        if (rd_acc) begin
            case (sel)
                SEL_CTRL:   prdata[7:0]        = ctrl;
                SEL_IEN:    prdata[STAT_W-1:0] = ien;
                SEL_PRESC:  prdata[PS_W-1:0]   = cfg_prescale;
                SEL_RDDATA: prdata[7:0]        = rd_empty ? 8'h00 : rd_head;
                SEL_STATUS: prdata[STAT_W-1:0] = stat;
                default:    prdata             = '0;
            endcase
        end
    end

    // R3: a stalled head command stays put unless the enable is rewritten
    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (eng_cmd_valid && !eng_cmd_ready && !(wr_acc && sel == SEL_CTRL))
        |=> (eng_cmd_valid && $stable(eng_cmd_data)));
    // R7: reading an empty read-data queue records underflow
    p_ufl_on_empty_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_empty) |=> stat.rd_ufl);
    // R4: a write into a full command queue records overflow
    p_ovf_on_full_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd_full) |=> stat.cmd_ovf);

endmodule

// File: tb/test_apb_i2c_front.sv
module test_apb_i2c_front;
    localparam int CLK_PERIOD = 10;
    localparam int CMD_DEPTH  = 32;
    localparam int RD_DEPTH   = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [4:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        eng_cmd_valid, eng_cmd_ready = 0;
    logic [7:0]  eng_cmd_data;
    logic        eng_rd_valid = 0;
    logic [7:0]  eng_rd_data = '0;
    logic        eng_bus_err = 0;
    logic        cfg_enable, cfg_clk_sel, cfg_div_en;
    logic [4:0]  cfg_div_low;
    logic [7:0]  cfg_prescale;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    apb_i2c_front #(.CMD_DEPTH(CMD_DEPTH), .RD_DEPTH(RD_DEPTH)) i_apb_i2c_front (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .eng_cmd_valid(eng_cmd_valid),
        .eng_cmd_ready(eng_cmd_ready), .eng_cmd_data(eng_cmd_data),
        .eng_rd_valid(eng_rd_valid), .eng_rd_data(eng_rd_data),
        .eng_bus_err(eng_bus_err), .cfg_enable(cfg_enable),
        .cfg_clk_sel(cfg_clk_sel), .cfg_div_en(cfg_div_en),
        .cfg_div_low(cfg_div_low), .cfg_prescale(cfg_prescale), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // behavioural reference state
    logic [7:0] m_ctrl = 0, m_ps = 0;
    logic [4:0] m_ien = 0;
    logic       m_ovf = 0, m_ufl = 0, m_bus = 0, m_irq = 0;
    logic [7:0] m_cmd[$];
    logic [7:0] m_rd[$];
    logic [7:0] got_cmd[$];
    logic [31:0] last_rd;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [4:0] m_status();
        return {m_bus, m_ufl, m_ovf, m_cmd.size() == CMD_DEPTH, m_rd.size() != 0};
    endfunction

    // compare on this cycle, then advance the model across the clock edge
    task automatic tick();
        logic        acc, wr, rd, st_rd, good_rd, ovf_set, ufl_set;
        logic [2:0]  idx;
        logic [31:0] exp_rd;
        logic [4:0]  st;
        #1;
        acc = psel & penable; wr = acc & pwrite; rd = acc & ~pwrite;
        idx = paddr[4:2];
        st  = m_status();
        exp_rd = 0;
        if (rd) case (idx)
            3'd0: exp_rd = {24'd0, m_ctrl};
            3'd1: exp_rd = {27'd0, m_ien};
            3'd2: exp_rd = {24'd0, m_ps};
            3'd4: exp_rd = (m_rd.size() != 0) ? {24'd0, m_rd[0]} : 0;
            3'd5: exp_rd = {27'd0, st};
            default: exp_rd = 0;
        endcase
        chk("R9 pready/pslverr", {pready, pslverr}, 2'b10);
        chk("R2 cfg outputs", {cfg_enable, cfg_clk_sel, cfg_div_en, cfg_div_low, cfg_prescale},
            {m_ctrl, m_ps});
        chk("R3 cmd valid", eng_cmd_valid, m_ctrl[7] && m_cmd.size() != 0);
        if (eng_cmd_valid && m_cmd.size() != 0) chk("R3 cmd data", eng_cmd_data, m_cmd[0]);
        chk("R8 irq", irq, m_irq);
        chk("R9 prdata", prdata, exp_rd);
        last_rd = prdata;
        if (eng_cmd_valid && eng_cmd_ready) got_cmd.push_back(eng_cmd_data);
        // next state
        st_rd   = rd && idx == 3'd5;
        ovf_set = wr && idx == 3'd3 && m_cmd.size() == CMD_DEPTH;
        ufl_set = rd && idx == 3'd4 && m_rd.size() == 0;
        good_rd = rd && idx == 3'd4 && m_rd.size() != 0;
        m_irq   = st_rd ? 1'b0 : (m_irq | (|(st & m_ien)));
        m_ovf   = ovf_set | (m_ovf & ~st_rd);
        m_ufl   = ufl_set | (m_ufl & ~st_rd & ~good_rd);
        m_bus   = eng_bus_err | (m_bus & ~st_rd);
        if (m_ctrl[7] && m_cmd.size() != 0 && eng_cmd_ready) void'(m_cmd.pop_front());
        if (wr && idx == 3'd3 && !ovf_set) m_cmd.push_back(pwdata[7:0]);
        if (eng_rd_valid && m_rd.size() < RD_DEPTH) begin
            if (good_rd) begin void'(m_rd.pop_front()); good_rd = 0; end
            m_rd.push_back(eng_rd_data);
        end
        if (good_rd) void'(m_rd.pop_front());
        if (wr && idx == 3'd0) m_ctrl = pwdata[7:0];
        if (wr && idx == 3'd1) m_ien  = pwdata[4:0];
        if (wr && idx == 3'd2) m_ps   = pwdata[7:0];
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
        psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        tick();
        penable = 1;
        tick();
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [4:0] a, output logic [31:0] d);
        psel = 1; penable = 0; pwrite = 0; paddr = a;
        tick();
        penable = 1;
        tick();
        d = last_rd;
        psel = 0; penable = 0;
    endtask

    task automatic push_rd(input logic [7:0] b);
        eng_rd_valid = 1; eng_rd_data = b;
        tick();
        eng_rd_valid = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                $display("FAIL watchdog: got %0d cycles expected completion", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        apb_rd(5'h00, v); chk("R1 ctrl", v, 0);
        apb_rd(5'h04, v); chk("R1 ien", v, 0);
        apb_rd(5'h08, v); chk("R1 prescale", v, 0);
        apb_rd(5'h14, v); chk("R1 status", v, 0);
        chk("R1 irq/valid", {irq, eng_cmd_valid}, 2'b00);

        // R2: configuration registers
        apb_wr(5'h00, 32'h65);
        apb_wr(5'h08, 32'h3C);
        apb_rd(5'h00, v); chk("R2 ctrl", v, 32'h65);
        apb_rd(5'h08, v); chk("R2 prescale", v, 32'h3C);
        chk("R2 cfg pins", {cfg_enable, cfg_clk_sel, cfg_div_en, cfg_div_low}, 8'h65);

        // R3: no issue while disabled, then strict write order
        eng_cmd_ready = 1;
        apb_wr(5'h0C, 32'h11); apb_wr(5'h0C, 32'h22); apb_wr(5'h0C, 32'h13);
        idle(3);
        chk("R3 held while disabled", got_cmd.size(), 0);
        apb_wr(5'h00, 32'hE5);
        idle(5);
        chk("R3 count", got_cmd.size(), 3);
        if (got_cmd.size() == 3) begin
            chk("R3 order0", got_cmd[0], 8'h11);
            chk("R3 order1", got_cmd[1], 8'h22);
            chk("R3 order2", got_cmd[2], 8'h13);
        end
        got_cmd.delete();

        // R4 / R5 / R6: fill, overflow, sticky clear on status read
        apb_wr(5'h00, 32'h65);
        for (int i = 0; i < CMD_DEPTH; i++) apb_wr(5'h0C, 32'h40 + i);
        apb_rd(5'h14, v); chk("R5 full flag", v, 32'h02);
        apb_wr(5'h0C, 32'hFF);
        apb_rd(5'h14, v); chk("R4 overflow flag", v, 32'h06);
        apb_rd(5'h14, v); chk("R6 overflow cleared", v, 32'h02);
        apb_wr(5'h00, 32'hE5);
        idle(40);
        chk("R4 drained count", got_cmd.size(), CMD_DEPTH);
        foreach (got_cmd[i]) chk("R4 drained order", got_cmd[i], 32'h40 + i);
        got_cmd.delete();

        // R5 / R7: read-data queue and underflow
        push_rd(8'hA1); push_rd(8'hB2);
        apb_rd(5'h14, v); chk("R5 rd ready", v, 32'h01);
        apb_rd(5'h10, v); chk("R7 oldest first", v, 32'hA1);
        apb_rd(5'h10, v); chk("R7 second", v, 32'hB2);
        apb_rd(5'h10, v); chk("R7 empty read", v, 0);
        apb_rd(5'h14, v); chk("R7 underflow flag", v, 32'h08);
        apb_rd(5'h10, v); chk("R7 empty read again", v, 0);
        push_rd(8'h5A);
        apb_rd(5'h10, v); chk("R7 good read", v, 32'h5A);
        apb_rd(5'h14, v); chk("R7 underflow cleared by read", v, 0);

        // R10: read-data queue depth and dropped bytes
        for (int i = 0; i < 6; i++) push_rd(8'h60 + 8'(i));
        for (int i = 0; i < RD_DEPTH; i++) begin
            apb_rd(5'h10, v); chk("R10 kept byte", v, 32'h60 + i);
        end
        apb_rd(5'h10, v); chk("R10 extra bytes dropped", v, 0);
        apb_rd(5'h14, v); chk("R10 underflow after drops", v, 32'h08);

        // R5 / R8: bus error, interrupt and its clearing
        apb_wr(5'h04, 32'h10);
        eng_bus_err = 1; tick(); eng_bus_err = 0;
        idle(2);
        chk("R8 irq raised", irq, 1);
        apb_rd(5'h14, v); chk("R5 bus error flag", v, 32'h10);
        idle(1);
        chk("R8 irq cleared", irq, 0);
        apb_wr(5'h04, 32'h01);
        push_rd(8'h77);
        idle(2);
        chk("R8 level irq", irq, 1);
        apb_rd(5'h14, v); chk("R8 status with data", v, 32'h01);
        idle(2);
        chk("R8 irq reasserts", irq, 1);
        apb_rd(5'h10, v); chk("R8 drain", v, 32'h77);
        apb_wr(5'h04, 32'h00);
        apb_rd(5'h14, v);
        idle(1);

        // R9: read-only and unmapped offsets
        apb_wr(5'h14, 32'hFF);
        apb_wr(5'h10, 32'hFF);
        apb_rd(5'h14, v); chk("R9 status write ignored", v, 0);
        apb_rd(5'h10, v); chk("R9 rddata write ignored", v, 0);
        apb_rd(5'h0C, v); chk("R9 cmd reads zero", v, 0);
        apb_rd(5'h1C, v); chk("R9 unmapped reads zero", v, 0);
        apb_rd(5'h00, v); chk("R9 ctrl unchanged", v, 32'hE5);
        idle(3);
        chk("R9 no command issued", got_cmd.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule